// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is the read-side front end of a nonvolatile array that can be read as 16-bit words or as 8-bit bytes. A width-select input chooses the organisation. In word mode, all sixteen output lanes carry the addressed word. In byte mode, the top lane stops being an output and acts as a low-order address bit instead. That bit picks one half of the addressed word, and the chosen half always appears on lanes 7..0.

Two active-low controls gate the bus. Chip enable selects the device and puts it in standby when it is high. Output enable gates data onto the lanes. High impedance is modelled by a per-lane enable vector, and a disabled lane reads as zero on the data bus. An identification input makes the port return fixed vendor and device codes instead of array data. The array is an internal synchronous memory. It is filled through a simple load port, and every read has one clock of latency.

Top module: `dual_rom_port`

## Requirements
- R1: With ce_ni=0, oe_ni=0, wide_i=1 and sig_i=0, data_o equals the 16-bit word stored at addr_i and lane_oe_o is 16'hFFFF. A word written through ld_en_i/ld_addr_i/ld_data_i is the value read back.
- R2: With ce_ni=0, oe_ni=0 and wide_i=0, data_o[7:0] carries bits 7..0 of the addressed word when lsb_i=0 and bits 15..8 when lsb_i=1.
- R3: In byte mode, lane_oe_o equals 16'h00FF, so lanes 15..8 are high impedance, including lane 15, which serves as the address bit.
- R4: With ce_ni=1, lane_oe_o is 0 and standby_o is 1, whatever the value of oe_ni.
- R5: With ce_ni=0 and oe_ni=1, lane_oe_o is 0 and standby_o is 0.
- R6: With ce_ni=0, oe_ni=0, wide_i=1 and sig_i=1, data_o[7:0] is 8'h20 when addr_i[0]=0 and 8'hB1 when addr_i[0]=1, and lane_oe_o is 16'hFFFF.
- R7: In identification mode, data_o[15:8] is zero.
- R8: Outputs change on the first clock edge after the inputs change, and not before it. A switch between word mode, byte mode and identification takes effect on the very next read, with no extra cycles.
- R9: Every lane whose lane_oe_o bit is 0 reads as 0 on data_o.
- R10: sig_i has no effect when wide_i=0, and the read returns byte data.
- R11: While rst_ni is low and after it is released, until the first sampled read, standby_o is 1 and lane_oe_o and data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Array load strobe |
| ld_addr_i | input | AW | Array load word address |
| ld_data_i | input | 16 | Array load word |
| addr_i | input | AW | Read word address |
| lsb_i | input | 1 | Byte-select address bit, used in byte mode only |
| wide_i | input | 1 | 1 = word mode, 0 = byte mode |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| sig_i | input | 1 | Identification mode request |
| data_o | output | 16 | Output data lanes |
| lane_oe_o | output | 16 | Per-lane drive enable; 0 models high impedance |
| standby_o | output | 1 | Standby status |

## Verification
Word reads at the lowest address, the highest address and middle addresses are compared with a bench-computed fill pattern whose two halves differ, so a swapped or truncated half is caught. Byte reads with each value of the select bit at the same addresses separate lower-half from upper-half selection. The identification tests vary address bit 0 and use an address with only its top bit set, which separates code selection from array data. A back-to-back sequence of word, byte, identification and word reads, each sampled just before and just after its clock edge, shows the one-cycle latency. Every combination of the two enables, with the identification request held in byte mode, shows that the gating and the ignored input behave as required.

// File: rtl/drp_pkg.sv
package drp_pkg;
  localparam int DW = 16;
  localparam int BW = 8;

  typedef enum logic [2:0] {
    M_STBY = 3'd0,
    M_DIS  = 3'd1,
    M_WORD = 3'd2,
    M_BLO  = 3'd3,
    M_BHI  = 3'd4,
    M_SIG  = 3'd5
  } mode_e;
endpackage

// File: rtl/drp_rom_array.sv
module drp_rom_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/drp_mode_decode.sv
module drp_mode_decode
  import drp_pkg::*;
(
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  wide_i,
  input  logic  lsb_i,
  input  logic  sig_i,
  output mode_e mode_o
);
  always_comb begin
    if (ce_ni)       mode_o = M_STBY;
    else if (oe_ni)  mode_o = M_DIS;
    else if (wide_i) mode_o = sig_i ? M_SIG : M_WORD;
    // byte mode: identification request ignored
    else             mode_o = lsb_i ? M_BHI : M_BLO;
  end
endmodule

// File: rtl/drp_lane_mux.sv
module drp_lane_mux
  import drp_pkg::*;
#(
  parameter logic [7:0] VEND = 8'h20,
  parameter logic [7:0] DEV  = 8'hB1
) (
  input  mode_e         mode_i,
  input  logic          sig_sel_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] oe_o
);
  localparam logic [DW-1:0] LOW_LANES = {{(DW-BW){1'b0}}, {BW{1'b1}}};

  logic [DW-1:0] raw;

  always_comb begin
    raw  = '0;
    oe_o = '0;
    unique case (mode_i)
      M_WORD: begin raw = word_i;                              oe_o = '1;        end
      M_BLO:  begin raw = {{(DW-BW){1'b0}}, word_i[BW-1:0]};   oe_o = LOW_LANES; end
      M_BHI:  begin raw = {{(DW-BW){1'b0}}, word_i[DW-1:BW]};  oe_o = LOW_LANES; end
      M_SIG:  begin raw = {{(DW-BW){1'b0}}, sig_sel_i ? DEV : VEND}; oe_o = '1;  end
      default: ;
    endcase
  end

  // undriven lanes read zero
  assign data_o = raw & oe_o;
endmodule

// File: rtl/dual_rom_port.sv
module dual_rom_port
  import drp_pkg::*;
#(
  parameter int         AW        = 8,
  parameter logic [7:0] VEND_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE  = 8'hB1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [15:0]   ld_data_i,
  input  logic [AW-1:0] addr_i,
  input  logic          lsb_i,
  input  logic          wide_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          sig_i,
  output logic [15:0]   data_o,
  output logic [15:0]   lane_oe_o,
  output logic          standby_o
);
  mode_e         mode_d, mode_q;
  logic          sig_sel_q;
  logic [DW-1:0] word_q;

  drp_rom_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .we_i    (ld_en_i),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (addr_i),
    .rdata_o (word_q)
  );

  drp_mode_decode u_dec (
    .ce_ni  (ce_ni),
    .oe_ni  (oe_ni),
    .wide_i (wide_i),
    .lsb_i  (lsb_i),
    .sig_i  (sig_i),
    .mode_o (mode_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_STBY;
      sig_sel_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      sig_sel_q <= addr_i[0];
    end
  end

  drp_lane_mux #(.VEND(VEND_CODE), .DEV(DEV_CODE)) u_mux (
    .mode_i    (mode_q),
    .sig_sel_i (sig_sel_q),
    .word_i    (word_q),
    .data_o    (data_o),
    .oe_o      (lane_oe_o)
  );

  assign standby_o = (mode_q == M_STBY);
endmodule

// File: rtl/drp_checker.sv
module drp_checker #(
  parameter logic [7:0] VEND = 8'h20,
  parameter logic [7:0] DEV  = 8'hB1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        addr0_i,
  input logic        wide_i,
  input logic        ce_ni,
  input logic        oe_ni,
  input logic        sig_i,
  input logic [15:0] data_o,
  input logic [15:0] lane_oe_o,
  input logic        standby_o
);
  AST_WORD_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && wide_i) |=> lane_oe_o == 16'hFFFF); // R1
  AST_BYTE_UPPER_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !wide_i) |=> lane_oe_o == 16'h00FF); // R3
  AST_STANDBY_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (standby_o && lane_oe_o == 16'h0)); // R4
  AST_DISABLE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |=> (!standby_o && lane_oe_o == 16'h0)); // R5
  AST_SIG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && wide_i && sig_i) |=> data_o[7:0] == ($past(addr0_i) ? DEV : VEND)); // R6
  AST_SIG_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && wide_i && sig_i) |=> data_o[15:8] == 8'h00); // R7
  AST_OFF_LANES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o & ~lane_oe_o) == 16'h0); // R9
endmodule

bind dual_rom_port drp_checker #(.VEND(VEND_CODE), .DEV(DEV_CODE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr0_i   (addr_i[0]),
  .wide_i    (wide_i),
  .ce_ni     (ce_ni),
  .oe_ni     (oe_ni),
  .sig_i     (sig_i),
  .data_o    (data_o),
  .lane_oe_o (lane_oe_o),
  .standby_o (standby_o)
);

// File: tb/dual_rom_port_tb.sv
module dual_rom_port_tb;
  localparam int AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_en_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0;
  logic [15:0]   ld_data_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic          lsb_i = 1'b0;
  logic          wide_i = 1'b1;
  logic          ce_ni = 1'b1;
  logic          oe_ni = 1'b1;
  logic          sig_i = 1'b0;
  logic [15:0]   data_o;
  logic [15:0]   lane_oe_o;
  logic          standby_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  dual_rom_port #(.AW(AW)) u_dut (.*);

  function automatic logic [15:0] fill(input logic [AW-1:0] a);
    return {a ^ 8'hC3, a + 8'h11};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, sample at the next negedge (one edge in between)
  task automatic rd(input logic ce, input logic oe, input logic wide, input logic lsb,
                    input logic sig, input logic [AW-1:0] a);
    @(negedge clk_i);
    ce_ni = ce; oe_ni = oe; wide_i = wide; lsb_i = lsb; sig_i = sig; addr_i = a;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    #1;
    chk("R11 standby in reset", {15'd0, standby_o}, 16'd1);
    chk("R11 lanes in reset", lane_oe_o, 16'h0);
    chk("R11 data in reset", data_o, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 standby after reset", {15'd0, standby_o}, 16'd1);
    chk("R11 lanes after reset", lane_oe_o, 16'h0);
  endtask

  task automatic t_load;
    for (int i = 0; i < (1 << AW); i++) begin
      @(negedge clk_i);
      ld_en_i = 1'b1; ld_addr_i = AW'(i); ld_data_i = fill(AW'(i));
    end
    @(negedge clk_i); ld_en_i = 1'b0;
  endtask

  task automatic t_word;
    logic [AW-1:0] al [4] = '{8'h00, 8'h01, 8'h7F, 8'hFF};
    foreach (al[i]) begin
      rd(0, 0, 1, 0, 0, al[i]);
      chk("R1 word data", data_o, fill(al[i]));
      chk("R1 word lanes", lane_oe_o, 16'hFFFF);
      chk("R1 not standby", {15'd0, standby_o}, 16'd0);
    end
  endtask

  task automatic t_byte;
    logic [AW-1:0] al [3] = '{8'h00, 8'h5A, 8'hFF};
    foreach (al[i]) begin
      rd(0, 0, 0, 0, 0, al[i]);
      chk("R2 byte low", data_o, {8'h00, fill(al[i])[7:0]});
      chk("R3 byte lanes", lane_oe_o, 16'h00FF);
      rd(0, 0, 0, 1, 0, al[i]);
      chk("R2 byte high", data_o, {8'h00, fill(al[i])[15:8]});
      chk("R3 byte lanes hi", lane_oe_o, 16'h00FF);
      chk("R9 upper byte zero", {8'h00, data_o[15:8]}, 16'h0);
    end
  endtask

  task automatic t_standby;
    rd(1, 0, 1, 0, 0, 8'h12);
    chk("R4 standby oe low lanes", lane_oe_o, 16'h0);
    chk("R4 standby flag", {15'd0, standby_o}, 16'd1);
    chk("R9 standby data", data_o, 16'h0);
    rd(1, 1, 0, 1, 1, 8'h12);
    chk("R4 standby oe high lanes", lane_oe_o, 16'h0);
    chk("R4 standby flag 2", {15'd0, standby_o}, 16'd1);
  endtask

  task automatic t_disable;
    rd(0, 1, 1, 0, 0, 8'h34);
    chk("R5 disable lanes", lane_oe_o, 16'h0);
    chk("R5 disable flag", {15'd0, standby_o}, 16'd0);
    chk("R9 disable data", data_o, 16'h0);
  endtask

  task automatic t_sig;
    rd(0, 0, 1, 0, 1, 8'h00);
    chk("R6 vendor code", data_o[7:0], 16'h20);
    chk("R7 vendor upper", {8'h00, data_o[15:8]}, 16'h0);
    chk("R6 sig lanes", lane_oe_o, 16'hFFFF);
    rd(0, 0, 1, 0, 1, 8'h01);
    chk("R6 device code", data_o, 16'h00B1);
    rd(0, 0, 1, 0, 1, 8'h80);
    chk("R6 vendor code at 0x80", data_o, 16'h0020);
  endtask

  task automatic t_sig_ignored;
    rd(0, 0, 0, 1, 1, 8'h01);
    chk("R10 sig ignored in byte mode", data_o, {8'h00, fill(8'h01)[15:8]});
    chk("R10 lanes byte", lane_oe_o, 16'h00FF);
  endtask

  task automatic t_toggle;
    rd(0, 0, 1, 0, 0, 8'h40);
    chk("R8 word before toggle", data_o, fill(8'h40));
    @(negedge clk_i);
    wide_i = 1'b0; lsb_i = 1'b1;
    #1 chk("R8 holds before edge", data_o, fill(8'h40));
    @(negedge clk_i);
    chk("R8 byte right after edge", data_o, {8'h00, fill(8'h40)[15:8]});
    wide_i = 1'b1; sig_i = 1'b1;
    #1 chk("R8 byte held before edge", lane_oe_o, 16'h00FF);
    @(negedge clk_i);
    chk("R8 sig right after edge", data_o, 16'h0020);
    sig_i = 1'b0; addr_i = 8'h41;
    @(negedge clk_i);
    chk("R8 word right after sig", data_o, fill(8'h41));
    chk("R8 word lanes", lane_oe_o, 16'hFFFF);
  endtask

  initial begin
    t_reset();
    t_load();
    t_word();
    t_byte();
    t_standby();
    t_disable();
    t_sig();
    t_sig_ignored();
    t_toggle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule